// File: doc/BRIEF.md
# Dual-Pointer Post-Modify Address Generator

This block produces two operand addresses in each issue cycle for a multiply-accumulate datapath that reads both of its operands indirectly. The first pointer is a general-purpose register. Its current value and its register number arrive from the register file. The second pointer is one of two dedicated index registers, chosen by a one-bit select. Each pointer uses the value it holds as the address, with bit 0 cleared so that the access is word aligned. After that use, the pointer is post-modified by a constant step or by an offset. The general pointer picks its offset from its own pair of offset inputs, and the index pointer picks from a separate pair.

The index pointer may only reach an on-chip dual-ported RAM window, set by the parameters `IDX_BASE` and `IDX_SIZE`. An index access outside that window raises an error flag, and the index register keeps its old value. A coprocessor-move issue removes this restriction. The general pointer may address the full 16-bit byte space, and all pointer arithmetic wraps modulo 2^16. The updated index value is presented together with the addresses. The updated general-purpose value is presented one cycle later, which lines up with an execute-stage register write-back.

Top module: `dual_ptr_agu`

## Requirements
- R1: A cycle with `issue_i` high produces `addr_vld_o` high in the next cycle, together with both addresses. `addr_vld_o` is low in every other cycle.
- R2: `gp_addr_o` is `gp_val_i` with bit 0 cleared. `ix_addr_o` is the selected index register with bit 0 cleared. `ix_sel_i`=0 selects `ix0_i` and `ix_sel_i`=1 selects `ix1_i`.
- R3: The 3-bit modify codes are: 000 no change, 001 add 2, 010 subtract 2, 011 add the offset, 100 subtract the offset. Codes 101, 110 and 111 act as no change. All results wrap modulo 2^16.
- R4: The general pointer's offset is `gp_ofs0_i` when `gp_ofs_sel_i`=0 and `gp_ofs1_i` when it is 1. The index pointer's offset is `ix_ofs0_i` when `ix_ofs_sel_i`=0 and `ix_ofs1_i` when it is 1.
- R5: The updated index value appears on `ix_wdata_o`, with `ix_wsel_o` equal to the issued `ix_sel_i`, in the same cycle as the addresses. `ix_we_o` is high only if the code changes the pointer and no range error occurred.
- R6: The updated general value appears on `gp_wdata_o`, with `gp_wsel_o` equal to the issued `gp_sel_i`, one cycle after the addresses. `gp_we_o` is high only if the code changes the pointer.
- R7: An index address A is inside the window when (A − IDX_BASE) mod 2^16 < IDX_SIZE. With the defaults this is 0xF600 to 0xF7FF. An address outside the window sets `range_err_o` with the addresses and holds `ix_we_o` low.
- R8: With `cmov_i` high, no range error is raised and the index update proceeds for any address.
- R9: The general pointer is never range checked. Its address and update are produced whatever the index error state is.
- R10: After reset, `addr_vld_o`, `range_err_o`, `ix_we_o` and `gp_we_o` are low.
- R11: Issues in consecutive cycles each produce their own addresses and write-backs, and neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Operand fetch request this cycle |
| cmov_i | input | 1 | Coprocessor move; lifts the index window limit |
| gp_sel_i | input | 4 | Register number of the general pointer |
| gp_val_i | input | 16 | Current value of the general pointer |
| gp_mode_i | input | 3 | General pointer modify code |
| gp_ofs_sel_i | input | 1 | General offset select |
| gp_ofs0_i | input | 16 | General offset 0 |
| gp_ofs1_i | input | 16 | General offset 1 |
| ix_sel_i | input | 1 | Index register select |
| ix0_i | input | 16 | Index register 0 value |
| ix1_i | input | 16 | Index register 1 value |
| ix_mode_i | input | 3 | Index pointer modify code |
| ix_ofs_sel_i | input | 1 | Index offset select |
| ix_ofs0_i | input | 16 | Index offset 0 |
| ix_ofs1_i | input | 16 | Index offset 1 |
| addr_vld_o | output | 1 | Addresses valid |
| gp_addr_o | output | 16 | General operand address |
| ix_addr_o | output | 16 | Index operand address |
| range_err_o | output | 1 | Index address outside window |
| ix_we_o | output | 1 | Index register write enable |
| ix_wsel_o | output | 1 | Index register to write |
| ix_wdata_o | output | 16 | Updated index value |
| gp_we_o | output | 1 | General register write enable |
| gp_wsel_o | output | 4 | General register to write |
| gp_wdata_o | output | 16 | Updated general value |

## Verification
The bench exercises the first and last words of the window and the words just outside each edge. A design with an off-by-one compare would either flag a legal word or let the neighbouring word through. It also decrements past zero and adds past 0xFFFF, where a lost carry or a sign error shows up as a wrong updated pointer. It issues the unused modify codes and an out-of-window index together with a modifying general code. A design that leaks the error into the general path, or that writes back on a dead code, would raise a write enable that must stay low. Back-to-back issues with the coprocessor-move bypass catch a write-back stage that drops or mixes up register numbers.

// File: rtl/agu_pkg.sv
// Package: modify codes and helpers shared by the address generator.
// Assumes byte addresses of AGU_AW bits with word-aligned accesses.
package agu_pkg;
    localparam int AGU_AW = 16;

    typedef enum logic [2:0] {
        PM_NONE   = 3'b000,
        PM_INC2   = 3'b001,
        PM_DEC2   = 3'b010,
        PM_ADDOFS = 3'b011,
        PM_SUBOFS = 3'b100
    } pmod_e;

    // True when a code changes the pointer.
    function automatic logic pmod_changes(input logic [2:0] code);
        return (code == PM_INC2) || (code == PM_DEC2) ||
               (code == PM_ADDOFS) || (code == PM_SUBOFS);
    endfunction
endpackage

// File: rtl/agu_ptr_update.sv
// Post-modify unit for one pointer: emits the aligned address taken from the
// old value, and the next pointer value. Purely combinational.
// Assumes codes outside the defined set mean "no change".
module agu_ptr_update
    import agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] ofs0_i,
    input  logic [AW-1:0] ofs1_i,
    input  logic          ofs_sel_i,
    input  logic [2:0]    mode_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] next_o,
    output logic          change_o
);
    localparam logic [AW-1:0] STEP = AW'(2);

    logic [AW-1:0] ofs;

    // Pick the offset register of this pointer's pair.
    always_comb ofs = ofs_sel_i ? ofs1_i : ofs0_i;

    // Address is the old pointer, word aligned.
    always_comb addr_o = {ptr_i[AW-1:1], 1'b0};

    // Next pointer value, modulo 2^AW.
    always_comb begin
        unique case (mode_i)
            PM_INC2:   next_o = ptr_i + STEP;
            PM_DEC2:   next_o = ptr_i - STEP;
            PM_ADDOFS: next_o = ptr_i + ofs;
            PM_SUBOFS: next_o = ptr_i - ofs;
            default:   next_o = ptr_i;
        endcase
    end

    // Flag whether the code modifies the pointer.
    always_comb change_o = pmod_changes(mode_i);
endmodule

// File: rtl/agu_window_check.sv
// Window check for the index pointer: flags an address outside
// [BASE, BASE+SIZE) with wrap-around arithmetic. Bypass forces "inside".
// Assumes SIZE <= 2^AW; SIZE of zero makes every address outside.
module agu_window_check #(
    parameter int          AW   = 16,
    parameter logic [AW-1:0] BASE = 16'hF600,
    parameter logic [AW-1:0] SIZE = 16'h0200
) (
    input  logic [AW-1:0] addr_i,
    input  logic          bypass_i,
    output logic          outside_o
);
    logic [AW-1:0] rel;

    // Offset of the address from the window base, wrapping.
    always_comb rel = addr_i - BASE;

    // Outside when the offset reaches the window size, unless bypassed.
    always_comb outside_o = !bypass_i && (rel >= SIZE);
endmodule

// File: rtl/agu_wb_stage.sv
// One-cycle delay that presents the general pointer write-back in the
// execute stage. Assumes inputs are the registered decode-stage results.
module agu_wb_stage #(
    parameter int AW = 16,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic          change_i,
    input  logic [SW-1:0] sel_i,
    input  logic [AW-1:0] data_i,
    output logic          we_o,
    output logic [SW-1:0] sel_o,
    output logic [AW-1:0] data_o
);
    // Register the write-back request one stage later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_o   <= 1'b0;
            sel_o  <= '0;
            data_o <= '0;
        end else begin
            we_o   <= vld_i && change_i;
            sel_o  <= sel_i;
            data_o <= data_i;
        end
    end

    assert_wb_data_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> (data_o == $past(data_i)) && (sel_o == $past(sel_i)));
endmodule

// File: rtl/dual_ptr_agu.sv
// Dual-pointer post-modify address generator. One issue yields a general
// pointer address and an index pointer address in the next cycle. It also
// yields the index update in that same cycle, and the general update one
// cycle after that. Assumes register contents come from outside the block.
module dual_ptr_agu #(
    parameter int          AW       = agu_pkg::AGU_AW,
    parameter int          GP_NUM   = 16,
    parameter logic [AW-1:0] IDX_BASE = 16'hF600,
    parameter logic [AW-1:0] IDX_SIZE = 16'h0200
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      issue_i,
    input  logic                      cmov_i,
    input  logic [$clog2(GP_NUM)-1:0] gp_sel_i,
    input  logic [AW-1:0]             gp_val_i,
    input  logic [2:0]                gp_mode_i,
    input  logic                      gp_ofs_sel_i,
    input  logic [AW-1:0]             gp_ofs0_i,
    input  logic [AW-1:0]             gp_ofs1_i,
    input  logic                      ix_sel_i,
    input  logic [AW-1:0]             ix0_i,
    input  logic [AW-1:0]             ix1_i,
    input  logic [2:0]                ix_mode_i,
    input  logic                      ix_ofs_sel_i,
    input  logic [AW-1:0]             ix_ofs0_i,
    input  logic [AW-1:0]             ix_ofs1_i,
    output logic                      addr_vld_o,
    output logic [AW-1:0]             gp_addr_o,
    output logic [AW-1:0]             ix_addr_o,
    output logic                      range_err_o,
    output logic                      ix_we_o,
    output logic                      ix_wsel_o,
    output logic [AW-1:0]             ix_wdata_o,
    output logic                      gp_we_o,
    output logic [$clog2(GP_NUM)-1:0] gp_wsel_o,
    output logic [AW-1:0]             gp_wdata_o
);
    localparam int SW = $clog2(GP_NUM);

    logic [AW-1:0] ix_ptr;
    logic [AW-1:0] gp_addr_c, gp_next_c, ix_addr_c, ix_next_c;
    logic          gp_chg_c, ix_chg_c, ix_out_c;
    logic [AW-1:0] gp_next_q;
    logic          gp_chg_q;
    logic [SW-1:0] gp_sel_q;

    // Select the active index register.
    always_comb ix_ptr = ix_sel_i ? ix1_i : ix0_i;

    agu_ptr_update #(.AW(AW)) u_gp_upd (
        .ptr_i(gp_val_i), .ofs0_i(gp_ofs0_i), .ofs1_i(gp_ofs1_i),
        .ofs_sel_i(gp_ofs_sel_i), .mode_i(gp_mode_i),
        .addr_o(gp_addr_c), .next_o(gp_next_c), .change_o(gp_chg_c));

    agu_ptr_update #(.AW(AW)) u_ix_upd (
        .ptr_i(ix_ptr), .ofs0_i(ix_ofs0_i), .ofs1_i(ix_ofs1_i),
        .ofs_sel_i(ix_ofs_sel_i), .mode_i(ix_mode_i),
        .addr_o(ix_addr_c), .next_o(ix_next_c), .change_o(ix_chg_c));

    agu_window_check #(.AW(AW), .BASE(IDX_BASE), .SIZE(IDX_SIZE)) u_win (
        .addr_i(ix_addr_c), .bypass_i(cmov_i), .outside_o(ix_out_c));

    // Decode stage: register addresses, error and the index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_vld_o  <= 1'b0;
            gp_addr_o   <= '0;
            ix_addr_o   <= '0;
            range_err_o <= 1'b0;
            ix_we_o     <= 1'b0;
            ix_wsel_o   <= 1'b0;
            ix_wdata_o  <= '0;
            gp_next_q   <= '0;
            gp_chg_q    <= 1'b0;
            gp_sel_q    <= '0;
        end else begin
            addr_vld_o  <= issue_i;
            gp_addr_o   <= gp_addr_c;
            ix_addr_o   <= ix_addr_c;
            range_err_o <= issue_i && ix_out_c;
            ix_we_o     <= issue_i && ix_chg_c && !ix_out_c;
            ix_wsel_o   <= ix_sel_i;
            ix_wdata_o  <= ix_next_c;
            gp_next_q   <= gp_next_c;
            gp_chg_q    <= gp_chg_c;
            gp_sel_q    <= gp_sel_i;
        end
    end

    agu_wb_stage #(.AW(AW), .SW(SW)) u_gp_wb (
        .clk(clk), .rst_n(rst_n), .vld_i(addr_vld_o), .change_i(gp_chg_q),
        .sel_i(gp_sel_q), .data_i(gp_next_q),
        .we_o(gp_we_o), .sel_o(gp_wsel_o), .data_o(gp_wdata_o));

    assert_vld_follows_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue_i)) |-> addr_vld_o);
    assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld_o |-> (!gp_addr_o[0] && !ix_addr_o[0]));
    assert_ix_we_needs_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ix_we_o |-> addr_vld_o);
    assert_gp_wb_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gp_we_o |-> $past(addr_vld_o));
    assert_err_blocks_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        range_err_o |-> (!ix_we_o && addr_vld_o));
    assert_cmov_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue_i && cmov_i)) |-> !range_err_o);
endmodule

// File: tb/test_dual_ptr_agu.sv
module test_dual_ptr_agu;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue = 0, cmov = 0, gofs_sel = 0, isel = 0, iofs_sel = 0;
    logic [3:0] gsel = 0;
    logic [2:0] gmode = 0, imode = 0;
    logic [15:0] gval = 0, gofs0 = 0, gofs1 = 0, ix0 = 0, ix1 = 0, iofs0 = 0, iofs1 = 0;
    logic avld, rerr, iwe, iwsel, gwe;
    logic [15:0] gaddr, iaddr, iwdata, gwdata;
    logic [3:0] gwsel;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_ptr_agu i_dual_ptr_agu (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .cmov_i(cmov),
        .gp_sel_i(gsel), .gp_val_i(gval), .gp_mode_i(gmode), .gp_ofs_sel_i(gofs_sel),
        .gp_ofs0_i(gofs0), .gp_ofs1_i(gofs1), .ix_sel_i(isel), .ix0_i(ix0), .ix1_i(ix1),
        .ix_mode_i(imode), .ix_ofs_sel_i(iofs_sel), .ix_ofs0_i(iofs0), .ix_ofs1_i(iofs1),
        .addr_vld_o(avld), .gp_addr_o(gaddr), .ix_addr_o(iaddr), .range_err_o(rerr),
        .ix_we_o(iwe), .ix_wsel_o(iwsel), .ix_wdata_o(iwdata),
        .gp_we_o(gwe), .gp_wsel_o(gwsel), .gp_wdata_o(gwdata));

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one issue at a falling edge; return just after the decode edge.
    task automatic issue_one(input logic [15:0] gv, input logic [3:0] gs, input logic [2:0] gm,
                             input logic gos, input logic is, input logic [2:0] im,
                             input logic ios, input logic cm);
        @(negedge clk);
        gval = gv; gsel = gs; gmode = gm; gofs_sel = gos;
        isel = is; imode = im; iofs_sel = ios; cmov = cm; issue = 1;
        @(posedge clk); #1;
        @(negedge clk); issue = 0; cmov = 0;
        #0;
    endtask

    // Reset state of all strobes (R10).
    task automatic t_reset;
        chk("R10", "addr_vld", 16'(avld), 0);
        chk("R10", "range_err", 16'(rerr), 0);
        chk("R10", "ix_we", 16'(iwe), 0);
        chk("R10", "gp_we", 16'(gwe), 0);
    endtask

    // Step modes, alignment and write-back timing (R1 R2 R3 R5 R6).
    task automatic t_steps;
        ix1 = 16'hF700;
        issue_one(16'h1235, 4'd7, 3'b001, 0, 1, 3'b010, 0, 0);
        chk("R1", "addr_vld", 16'(avld), 1);
        chk("R2", "gp_addr", gaddr, 16'h1234);
        chk("R2", "ix_addr", iaddr, 16'hF700);
        chk("R5", "ix_we", 16'(iwe), 1);
        chk("R5", "ix_wsel", 16'(iwsel), 1);
        chk("R3", "ix_wdata", iwdata, 16'hF6FE);
        chk("R6", "gp_we early", 16'(gwe), 0);
        @(posedge clk); #1;
        chk("R1", "addr_vld one cycle", 16'(avld), 0);
        chk("R6", "gp_we", 16'(gwe), 1);
        chk("R6", "gp_wsel", 16'(gwsel), 7);
        chk("R3", "gp_wdata", gwdata, 16'h1237);
    endtask

    // Offset modes, offset selects and wrap (R3 R4).
    task automatic t_offsets;
        gofs0 = 16'h0100; gofs1 = 16'h0010; ix0 = 16'hF610; iofs0 = 16'h0008; iofs1 = 16'h0020;
        issue_one(16'hFFF8, 4'd2, 3'b011, 1, 0, 3'b100, 1, 0);
        chk("R2", "ix_addr sel0", iaddr, 16'hF610);
        chk("R4", "ix_wdata ofs1", iwdata, 16'hF5F0);
        chk("R7", "inside no err", 16'(rerr), 0);
        @(posedge clk); #1;
        chk("R4", "gp_wdata ofs1 wrap", gwdata, 16'h0008);
        issue_one(16'h0004, 4'd3, 3'b100, 0, 0, 3'b011, 0, 0);
        chk("R4", "ix_wdata ofs0", iwdata, 16'hF618);
        @(posedge clk); #1;
        chk("R3", "gp_wdata sub wrap", gwdata, 16'hFF04);
    endtask

    // No-change codes give no write enables (R3 R5 R6).
    task automatic t_nochange;
        ix0 = 16'hF620;
        issue_one(16'h2000, 4'd1, 3'b000, 0, 0, 3'b101, 0, 0);
        chk("R5", "ix_we code101", 16'(iwe), 0);
        chk("R7", "no err", 16'(rerr), 0);
        @(posedge clk); #1;
        chk("R6", "gp_we code000", 16'(gwe), 0);
        issue_one(16'h2000, 4'd1, 3'b111, 0, 0, 3'b000, 0, 0);
        chk("R5", "ix_we code000", 16'(iwe), 0);
        @(posedge clk); #1;
        chk("R3", "gp_we code111", 16'(gwe), 0);
    endtask

    // Window edges and the general pointer staying unaffected (R7 R9).
    task automatic t_window;
        logic [15:0] probe [4] = '{16'hF5FE, 16'hF600, 16'hF7FE, 16'hF800};
        logic        bad   [4] = '{1'b1, 1'b0, 1'b0, 1'b1};
        for (int k = 0; k < 4; k++) begin
            ix0 = probe[k];
            issue_one(16'h0100, 4'd5, 3'b001, 0, 0, 3'b001, 0, 0);
            chk("R7", $sformatf("err @%h", probe[k]), 16'(rerr), 16'(bad[k]));
            chk("R7", $sformatf("ix_we @%h", probe[k]), 16'(iwe), 16'(!bad[k]));
            chk("R9", "gp_addr", gaddr, 16'h0100);
            @(posedge clk); #1;
            chk("R9", "gp_we despite ix err", 16'(gwe), 1);
            chk("R9", "gp_wdata", gwdata, 16'h0102);
        end
    endtask

    // Coprocessor move lifts the window (R8).
    task automatic t_cmov;
        ix1 = 16'h1000;
        issue_one(16'h0000, 4'd0, 3'b000, 0, 1, 3'b001, 0, 1);
        chk("R8", "no err", 16'(rerr), 0);
        chk("R8", "ix_we", 16'(iwe), 1);
        chk("R8", "ix_wdata", iwdata, 16'h1002);
    endtask

    // Two issues in consecutive cycles (R11).
    task automatic t_back2back;
        ix0 = 16'hF640; ix1 = 16'hF680;
        @(negedge clk);
        gval = 16'h3000; gsel = 4'd9; gmode = 3'b001; isel = 0; imode = 3'b001; issue = 1;
        @(negedge clk);
        chk("R11", "first gp_addr", gaddr, 16'h3000);
        chk("R11", "first ix_addr", iaddr, 16'hF640);
        gval = 16'h4000; gsel = 4'd10; gmode = 3'b010; isel = 1; imode = 3'b010;
        @(negedge clk); issue = 0;
        chk("R11", "second gp_addr", gaddr, 16'h4000);
        chk("R11", "second ix_wdata", iwdata, 16'hF67E);
        chk("R11", "first gp_wsel", 16'(gwsel), 9);
        chk("R11", "first gp_wdata", gwdata, 16'h3002);
        @(negedge clk);
        chk("R11", "second gp_wsel", 16'(gwsel), 10);
        chk("R11", "second gp_wdata", gwdata, 16'h3FFE);
        chk("R11", "second gp_we", 16'(gwe), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1;
        t_steps();
        t_offsets();
        t_nochange();
        t_window();
        t_cmov();
        t_back2back();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule